// File: doc/BRIEF.md
# Second-Operand Shifter and Immediate Rotator

This combinational unit builds the second operand of a data-processing datapath together with a shifter carry. In shift mode it takes a register value and applies one of five shift kinds. The shift count comes either from a 5-bit field in the instruction or from the low byte of another register. In immediate mode it ignores the register value. It widens an 8-bit constant to 32 bits and rotates it right by twice a 4-bit field.

The carry output is the last bit pushed out of the value. When nothing moves, the incoming C flag passes through unchanged, so the flag logic that follows can always take the carry from here. The block has no state and no clock, so there are no states or transitions. Every output is a pure function of the inputs present in the same cycle. Register reads and the ALU sit outside.

Top module: `op2_shifter`

## Requirements
- R1: Shift kind 0 is logical left. For a count n in 1..31, the result is the value shifted left by n with zeros filled in, and the carry is value bit 32-n.
- R2: Shift kind 1 is logical right. For n in 1..31, the result is the value shifted right by n with zeros filled in, and the carry is value bit n-1.
- R3: Shift kind 2 is arithmetic right. For n in 1..31, the vacated upper bits copy value bit 31, and the carry is value bit n-1.
- R4: Shift kind 3 is rotate right. For a count whose low five bits m are nonzero, the result is the value rotated right by m, and the carry is value bit m-1.
- R5: Shift kind 4 is rotate right extended. The result is the value shifted right by one with the incoming C in bit 31, and the carry is value bit 0. The count is not used.
- R6: For shift kinds 0 to 3, a count of zero from either source leaves the value unchanged and passes the incoming C to the carry.
- R7: When `amt_from_reg` is 1, the count is bits 7:0 of `amt_reg`. Bits 31:8 have no effect. When it is 0, the count is `amt_imm`.
- R8: A logical shift of exactly 32 gives zero. The carry is value bit 0 for a left shift and value bit 31 for a right shift. A logical count above 32 gives zero with carry 0.
- R9: An arithmetic right shift of 32 or more fills every bit with value bit 31, and the carry is value bit 31.
- R10: A rotate count that is a nonzero multiple of 32 leaves the value unchanged, and the carry is value bit 31.
- R11: When `imm_mode` is 1, the result is `imm_byte` zero-extended to 32 bits and rotated right by 2×`imm_rot`. The register value and the shift inputs have no effect.
- R12: In immediate mode, a nonzero `imm_rot` makes the carry equal result bit 31. A zero `imm_rot` passes the incoming C.
- R13: Shift kind codes 5, 6 and 7 are reserved. In shift mode they pass the value unchanged, with the carry equal to the incoming C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_mode | input | 1 | 1 selects the rotated immediate, 0 selects the shifted register |
| src_val | input | 32 | Register value to shift |
| shift_kind | input | 3 | Shift kind code (0 to 4, 5 to 7 reserved) |
| amt_from_reg | input | 1 | 1 takes the count from `amt_reg`, 0 from `amt_imm` |
| amt_imm | input | 5 | Count from the instruction field |
| amt_reg | input | 32 | Register holding the count in its low byte |
| imm_byte | input | 8 | 8-bit immediate constant |
| imm_rot | input | 4 | Immediate rotate field, in units of two places |
| carry_in | input | 1 | Current C flag |
| op2_out | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The checker evaluates its immediate assertions whenever an input changes. It therefore assumes that the inputs are two-state, that they change together, and that no individual input moves between the others. The bench keeps to this by changing all inputs in one task at the falling clock edge. It compares outputs only after the following rising edge, when every combinational path has settled. Reserved shift codes and counts up to 255 are legal inputs and are driven on purpose, because the checker's properties cover them.

// File: rtl/op2_pkg.sv
package op2_pkg;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic {
        SRC_SHIFT = 1'b0,
        SRC_IMM   = 1'b1
    } op_src_e;

endpackage

// File: rtl/op2_rotr.sv
// Logarithmic right rotator: one conditional stage per count bit.
module op2_rotr #(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stg [0:SW];

    assign stg[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int STEP = 2 ** i;
        assign stg[i+1] = amt[i] ? {stg[i][STEP-1:0], stg[i][W-1:STEP]} : stg[i];
    end

    assign dout = stg[SW];

endmodule

// File: rtl/op2_imm_rotator.sv
// Expands a narrow constant by an even right rotation.
module op2_imm_rotator #(
    parameter int W     = 32,
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic [IMM_W-1:0] imm_byte,
    input  logic [ROT_W-1:0] imm_rot,
    input  logic             carry_in,
    output logic [W-1:0]     imm_val,
    output logic             imm_carry
);

    localparam int RSW = ROT_W + 1;

    logic [W-1:0]   widened;
    logic [RSW-1:0] rot_places;

    assign widened    = W'(imm_byte);
    assign rot_places = {imm_rot, 1'b0};

    op2_rotr #(.W(W), .SW(RSW)) u_rot (
        .din  (widened),
        .amt  (rot_places),
        .dout (imm_val)
    );

    assign imm_carry = (imm_rot != '0) ? imm_val[W-1] : carry_in;

endmodule

// File: rtl/op2_shift_unit.sv
// Register-operand shifter: all shift kinds share one rotator plus masks.
module op2_shift_unit
    import op2_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [W-1:0]  din,
    input  logic [2:0]    kind,
    input  logic [AW-1:0] amt,
    input  logic          carry_in,
    output logic [W-1:0]  dout,
    output logic          cout
);

    localparam int SW = $clog2(W);

    shift_kind_e   k;
    logic [SW-1:0] low;
    logic [SW-1:0] rot_amt;
    logic [W-1:0]  rot;
    logic [W-1:0]  mask_r;
    logic [W-1:0]  mask_l;
    logic          amt_zero;
    logic          amt_full;
    logic          amt_over;
    logic          bit_r;
    logic          bit_l;
    logic          sign;

    assign k        = shift_kind_e'(kind);
    assign low      = amt[SW-1:0];
    assign amt_zero = (amt == '0);
    assign amt_full = (amt == AW'(W));
    assign amt_over = (amt > AW'(W));
    assign sign     = din[W-1];

    // A left shift by n is a right rotation by W-n, then masked.
    assign rot_amt = (k == SH_LSL) ? (SW'(0) - low) : low;

    op2_rotr #(.W(W), .SW(SW)) u_rot (
        .din  (din),
        .amt  (rot_amt),
        .dout (rot)
    );

    assign mask_r = {W{1'b1}} >> low;
    assign mask_l = {W{1'b1}} << low;
    assign bit_r  = din[low - SW'(1)];
    assign bit_l  = din[rot_amt];

    always_comb begin
        dout = din;
        cout = carry_in;
        unique case (k)
            SH_LSL: begin
                if (amt_over) begin
                    dout = '0;
                    cout = 1'b0;
                end else if (amt_full) begin
                    dout = '0;
                    cout = din[0];
                end else if (!amt_zero) begin
                    dout = rot & mask_l;
                    cout = bit_l;
                end
            end
            SH_LSR: begin
                if (amt_over) begin
                    dout = '0;
                    cout = 1'b0;
                end else if (amt_full) begin
                    dout = '0;
                    cout = sign;
                end else if (!amt_zero) begin
                    dout = rot & mask_r;
                    cout = bit_r;
                end
            end
            SH_ASR: begin
                if (amt_over || amt_full) begin
                    dout = {W{sign}};
                    cout = sign;
                end else if (!amt_zero) begin
                    dout = (rot & mask_r) | ({W{sign}} & ~mask_r);
                    cout = bit_r;
                end
            end
            SH_ROR: begin
                if (!amt_zero) begin
                    if (low == '0) begin
                        dout = din;
                        cout = sign;
                    end else begin
                        dout = rot;
                        cout = bit_r;
                    end
                end
            end
            SH_RRX: begin
                dout = {carry_in, din[W-1:1]};
                cout = din[0];
            end
            default: begin
                dout = din;
                cout = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/op2_shifter.sv
// Top: picks the count source, runs both paths, selects by mode.
module op2_shifter
    import op2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RAMT_W = 8,
    parameter int IAMT_W = 5,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic              imm_mode,
    input  logic [DATA_W-1:0] src_val,
    input  logic [2:0]        shift_kind,
    input  logic              amt_from_reg,
    input  logic [IAMT_W-1:0] amt_imm,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] op2_out,
    output logic              carry_out
);

    op_src_e           src_sel;
    logic [RAMT_W-1:0] count;
    logic [DATA_W-1:0] sh_val;
    logic              sh_carry;
    logic [DATA_W-1:0] im_val;
    logic              im_carry;

    assign src_sel = op_src_e'(imm_mode);
    assign count   = amt_from_reg ? amt_reg[RAMT_W-1:0] : RAMT_W'(amt_imm);

    op2_shift_unit #(.W(DATA_W), .AW(RAMT_W)) u_shift (
        .din      (src_val),
        .kind     (shift_kind),
        .amt      (count),
        .carry_in (carry_in),
        .dout     (sh_val),
        .cout     (sh_carry)
    );

    op2_imm_rotator #(.W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
        .imm_byte  (imm_byte),
        .imm_rot   (imm_rot),
        .carry_in  (carry_in),
        .imm_val   (im_val),
        .imm_carry (im_carry)
    );

    always_comb begin
        unique case (src_sel)
            SRC_IMM: begin
                op2_out   = im_val;
                carry_out = im_carry;
            end
            default: begin
                op2_out   = sh_val;
                carry_out = sh_carry;
            end
        endcase
    end

endmodule

// File: rtl/op2_checks.sv
module op2_checks #(
    parameter int DATA_W = 32,
    parameter int RAMT_W = 8,
    parameter int IAMT_W = 5,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input logic              imm_mode,
    input logic [DATA_W-1:0] src_val,
    input logic [2:0]        shift_kind,
    input logic              amt_from_reg,
    input logic [IAMT_W-1:0] amt_imm,
    input logic [DATA_W-1:0] amt_reg,
    input logic [IMM_W-1:0]  imm_byte,
    input logic [ROT_W-1:0]  imm_rot,
    input logic              carry_in,
    input logic [DATA_W-1:0] op2_out,
    input logic              carry_out
);

    logic [RAMT_W-1:0] n;
    assign n = amt_from_reg ? amt_reg[RAMT_W-1:0] : RAMT_W'(amt_imm);

    always_comb begin
        if (!imm_mode && shift_kind == 3'd4) begin
            p_rrx_r5: assert (op2_out == {carry_in, src_val[DATA_W-1:1]} && carry_out == src_val[0]);
        end
        if (!imm_mode && shift_kind <= 3'd3 && n == '0) begin
            p_zero_count_r6: assert (op2_out == src_val && carry_out == carry_in);
        end
        if (!imm_mode && shift_kind <= 3'd1 && n > RAMT_W'(DATA_W)) begin
            p_logical_over_r8: assert (op2_out == '0 && !carry_out);
        end
        if (!imm_mode && shift_kind == 3'd2 && n >= RAMT_W'(DATA_W)) begin
            p_asr_fill_r9: assert (op2_out == {DATA_W{src_val[DATA_W-1]}} && carry_out == src_val[DATA_W-1]);
        end
        if (!imm_mode && shift_kind == 3'd3 && n != '0 && n % RAMT_W'(DATA_W) == '0) begin
            p_ror_multiple_r10: assert (op2_out == src_val && carry_out == src_val[DATA_W-1]);
        end
        if (imm_mode && imm_rot == '0) begin
            p_imm_norot_r12: assert (op2_out == DATA_W'(imm_byte) && carry_out == carry_in);
        end
        if (imm_mode && imm_rot != '0) begin
            p_imm_carry_r12: assert (carry_out == op2_out[DATA_W-1]);
        end
        if (imm_mode) begin
            p_imm_popcount_r11: assert ($countones(op2_out) == $countones(imm_byte));
        end
        if (!imm_mode && shift_kind >= 3'd5) begin
            p_reserved_pass_r13: assert (op2_out == src_val && carry_out == carry_in);
        end
    end

endmodule

bind op2_shifter op2_checks #(
    .DATA_W (DATA_W),
    .RAMT_W (RAMT_W),
    .IAMT_W (IAMT_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
) u_chk (
    .imm_mode     (imm_mode),
    .src_val      (src_val),
    .shift_kind   (shift_kind),
    .amt_from_reg (amt_from_reg),
    .amt_imm      (amt_imm),
    .amt_reg      (amt_reg),
    .imm_byte     (imm_byte),
    .imm_rot      (imm_rot),
    .carry_in     (carry_in),
    .op2_out      (op2_out),
    .carry_out    (carry_out)
);

// File: tb/op2_shifter_tb.sv
module op2_shifter_tb;

    logic        clk = 1'b0;
    logic        imm_mode = 1'b0;
    logic [31:0] src_val = '0;
    logic [2:0]  shift_kind = '0;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  amt_imm = '0;
    logic [31:0] amt_reg = '0;
    logic [7:0]  imm_byte = '0;
    logic [3:0]  imm_rot = '0;
    logic        carry_in = 1'b0;
    logic [31:0] op2_out;
    logic        carry_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    op2_shifter u_dut (
        .imm_mode     (imm_mode),
        .src_val      (src_val),
        .shift_kind   (shift_kind),
        .amt_from_reg (amt_from_reg),
        .amt_imm      (amt_imm),
        .amt_reg      (amt_reg),
        .imm_byte     (imm_byte),
        .imm_rot      (imm_rot),
        .carry_in     (carry_in),
        .op2_out      (op2_out),
        .carry_out    (carry_out)
    );

    // Behavioural model: moves one bit per loop step and records what falls out.
    function automatic logic [32:0] model(
        input logic im, input logic [31:0] v, input logic [2:0] k,
        input logic fr, input logic [4:0] ai, input logic [31:0] ar,
        input logic [7:0] b, input logic [3:0] r, input logic c);
        logic [31:0] x;
        logic        cc;
        int          n;
        cc = c;
        if (im) begin
            x = {24'd0, b};
            for (int i = 0; i < 2 * int'(r); i++) begin
                cc = x[0];
                x  = {x[0], x[31:1]};
            end
            if (r == 4'd0) cc = c;
            return {cc, x};
        end
        x = v;
        n = fr ? int'(ar[7:0]) : int'(ai);
        case (k)
            3'd0: for (int i = 0; i < n; i++) begin cc = x[31]; x = {x[30:0], 1'b0}; end
            3'd1: for (int i = 0; i < n; i++) begin cc = x[0]; x = {1'b0, x[31:1]}; end
            3'd2: for (int i = 0; i < n; i++) begin cc = x[0]; x = {x[31], x[31:1]}; end
            3'd3: for (int i = 0; i < n; i++) begin cc = x[0]; x = {x[0], x[31:1]}; end
            3'd4: begin cc = x[0]; x = {c, x[31:1]}; end
            default: ;
        endcase
        return {cc, x};
    endfunction

    task automatic apply(input string tag, input logic im, input logic [31:0] v,
                         input logic [2:0] k, input logic fr, input logic [4:0] ai,
                         input logic [31:0] ar, input logic [7:0] b, input logic [3:0] r,
                         input logic c);
        logic [32:0] exp;
        @(negedge clk);
        imm_mode = im; src_val = v; shift_kind = k; amt_from_reg = fr;
        amt_imm = ai; amt_reg = ar; imm_byte = b; imm_rot = r; carry_in = c;
        @(posedge clk);
        #1;
        exp = model(im, v, k, fr, ai, ar, b, r, c);
        checks++;
        if ({carry_out, op2_out} !== exp) begin
            errors++;
            $display("FAIL %s: actual carry=%0b val=%08h expected carry=%0b val=%08h",
                     tag, carry_out, op2_out, exp[32], exp[31:0]);
        end
    endtask

    function automatic string tag_of(input logic im, input logic [2:0] k,
                                     input logic fr, input logic [4:0] ai, input logic [31:0] ar);
        int n;
        n = fr ? int'(ar[7:0]) : int'(ai);
        if (im) return "R11";
        if (k >= 3'd5) return "R13";
        if (k == 3'd4) return "R5";
        if (n == 0) return "R6";
        if (k == 3'd3) return (n % 32 == 0) ? "R10" : "R4";
        if (k == 3'd2) return (n >= 32) ? "R9" : "R3";
        if (n >= 32) return "R8";
        return (k == 3'd0) ? "R1" : "R2";
    endfunction

    initial begin : watchdog
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // all-zero inputs: value and carry stay zero (R6)
        apply("R6", 0, 32'h0, 3'd0, 0, 5'd0, 32'h0, 8'h0, 4'h0, 0);
        // R1 logical left
        apply("R1", 0, 32'h8000_0001, 3'd0, 0, 5'd1, 32'h0, 8'h0, 4'h0, 0);
        apply("R1", 0, 32'hF000_000F, 3'd0, 0, 5'd4, 32'h0, 8'h0, 4'h0, 0);
        apply("R1", 0, 32'h0000_0003, 3'd0, 0, 5'd31, 32'h0, 8'h0, 4'h0, 1);
        // R2 logical right
        apply("R2", 0, 32'h8000_001F, 3'd1, 0, 5'd4, 32'h0, 8'h0, 4'h0, 0);
        apply("R2", 0, 32'hC000_0000, 3'd1, 1, 5'd0, 32'd31, 8'h0, 4'h0, 0);
        // R3 arithmetic right
        apply("R3", 0, 32'h8000_0080, 3'd2, 0, 5'd8, 32'h0, 8'h0, 4'h0, 0);
        apply("R3", 0, 32'h7FFF_FFFF, 3'd2, 0, 5'd30, 32'h0, 8'h0, 4'h0, 0);
        // R4 rotate right
        apply("R4", 0, 32'h1234_5678, 3'd3, 0, 5'd8, 32'h0, 8'h0, 4'h0, 0);
        apply("R4", 0, 32'h1234_5678, 3'd3, 1, 5'd0, 32'd33, 8'h0, 4'h0, 0);
        // R5 rotate right extended
        apply("R5", 0, 32'h0000_0003, 3'd4, 0, 5'd9, 32'h0, 8'h0, 4'h0, 1);
        apply("R5", 0, 32'hFFFF_FFFE, 3'd4, 1, 5'd0, 32'd7, 8'h0, 4'h0, 0);
        // R6 zero count, both sources
        apply("R6", 0, 32'hDEAD_BEEF, 3'd1, 0, 5'd0, 32'd5, 8'h0, 4'h0, 1);
        apply("R6", 0, 32'hDEAD_BEEF, 3'd3, 1, 5'd7, 32'h0, 8'h0, 4'h0, 1);
        // R7 only low byte of the count register matters
        apply("R7", 0, 32'h0000_00F0, 3'd1, 1, 5'd0, 32'hFFFF_FF04, 8'h0, 4'h0, 0);
        apply("R7", 0, 32'hCAFE_F00D, 3'd0, 1, 5'd3, 32'h0000_0100, 8'h0, 4'h0, 1);
        // R8 logical at and beyond full width
        apply("R8", 0, 32'h7FFF_FFFF, 3'd0, 1, 5'd0, 32'd32, 8'h0, 4'h0, 0);
        apply("R8", 0, 32'h8000_0000, 3'd1, 1, 5'd0, 32'd32, 8'h0, 4'h0, 0);
        apply("R8", 0, 32'hFFFF_FFFF, 3'd0, 1, 5'd0, 32'd33, 8'h0, 4'h0, 1);
        apply("R8", 0, 32'hFFFF_FFFF, 3'd1, 1, 5'd0, 32'd200, 8'h0, 4'h0, 1);
        // R9 arithmetic at and beyond full width
        apply("R9", 0, 32'h8000_0000, 3'd2, 1, 5'd0, 32'd32, 8'h0, 4'h0, 0);
        apply("R9", 0, 32'h7FFF_FFFF, 3'd2, 1, 5'd0, 32'd255, 8'h0, 4'h0, 1);
        // R10 rotate by nonzero multiples of 32
        apply("R10", 0, 32'h8000_0001, 3'd3, 1, 5'd0, 32'd32, 8'h0, 4'h0, 0);
        apply("R10", 0, 32'h7000_0001, 3'd3, 1, 5'd0, 32'd64, 8'h0, 4'h0, 1);
        // R11 immediate expansion, shift inputs set to noise
        apply("R11", 1, 32'hFFFF_FFFF, 3'd2, 1, 5'd3, 32'd40, 8'hFF, 4'd4, 0);
        apply("R11", 1, 32'h1234_5678, 3'd0, 0, 5'd9, 32'h0, 8'hC3, 4'd15, 0);
        // R12 immediate carry
        apply("R12", 1, 32'h0, 3'd0, 0, 5'd0, 32'h0, 8'h81, 4'd0, 1);
        apply("R12", 1, 32'h0, 3'd0, 0, 5'd0, 32'h0, 8'h01, 4'd1, 1);
        apply("R12", 1, 32'h0, 3'd0, 0, 5'd0, 32'h0, 8'h02, 4'd1, 0);
        // R13 reserved codes
        apply("R13", 0, 32'hA5A5_5A5A, 3'd5, 0, 5'd4, 32'h0, 8'h0, 4'h0, 1);
        apply("R13", 0, 32'hA5A5_5A5A, 3'd6, 1, 5'd0, 32'd40, 8'h0, 4'h0, 0);
        apply("R13", 0, 32'h0000_0001, 3'd7, 0, 5'd31, 32'h0, 8'h0, 4'h0, 1);

        for (int i = 0; i < 3000; i++) begin
            logic        im;
            logic [2:0]  k;
            logic        fr;
            logic [4:0]  ai;
            logic [31:0] ar;
            im = ($urandom % 4) == 0;
            k  = 3'($urandom);
            fr = 1'($urandom);
            ai = 5'($urandom);
            ar = $urandom;
            if (($urandom % 3) == 0) ar[7:0] = 8'(32 * ($urandom % 3) + ($urandom % 3));
            apply(tag_of(im, k, fr, ai, ar), im, $urandom, k, fr, ai, ar,
                  8'($urandom), 4'($urandom), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule